// File: doc/BRIEF.md
# DMA Request Line Serializer and Grant Decoder

This block sits in a bus agent that owns several local DMA request lines but has only one active-low request pin and one active-low grant pin towards a central arbiter. It shifts a snapshot of all request lines out on the request pin: a low start bit, then one bit per channel in ascending channel order, then a low level that persists until the next report. A change in the request set is reported by letting the pin go high for one clock and then sending a new snapshot. If the channel currently being served withdraws its request, the pin goes high for two clocks instead.

The arbiter answers on the grant pin with a low start bit followed by the served channel number, least significant bit first. The block turns that message into a one-hot acknowledge vector, which stays valid while the grant pin remains low. During the grant, the arbiter runs I/O cycles to the agent. The block decodes the cycle offset into a data-transfer strobe or a verify strobe, plus a flag that marks the final (terminal-count) transfer.

Top module: `dma_req_link`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `req_n` is 1, `ack` is all zero, and `data_stb`, `verify_stb` and `tc_flag` are 0.
- R2: From idle, a non-empty request set appears on `req_n` one clock after it is sampled. The frame is a 0 start bit, then eight bits for channels 0 to 7 in order, each 0 when that channel's `chan_req` bit is 1. After the last bit, `req_n` stays 0.
- R3: The bits of a frame come from the request set captured for its start bit. A change made during a frame is reported only after that frame and one tail clock, as exactly one clock of `req_n` high followed by a new frame.
- R4: While a grant is live, a drop of the served channel's request is reported as exactly two clocks of `req_n` high, followed by a new frame.
- R5: A frame reporting an empty set (all bits 1) is followed by `req_n` staying 1 (idle) rather than a low tail.
- R6: When a grant ends while the last reported set still holds other channels, the set is re-sent with a one-clock high gap, even though `chan_req` is unchanged.
- R7: A grant message on `gnt_n` is a 0 start bit followed by three channel bits, LSB first. One clock after the last bit, `ack` is one-hot at that channel. It holds while `gnt_n` stays 0 and clears one clock after `gnt_n` is sampled 1.
- R8: While a grant is live, an I/O cycle (`io_cyc`=1) raises a one-clock strobe in the next cycle. Offset 00h or 04h raises `data_stb` in either direction. A read (`io_rd`=1) at C0h or C4h raises `verify_stb`. `tc_flag` is 1 with the strobe for 04h and C4h.
- R9: No strobe is raised for any other offset, for a write to C0h or C4h, or when no grant is live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req | input | NCH | Local DMA requests, 1 = active |
| req_n | output | 1 | Serial request pin to the arbiter, active low |
| gnt_n | input | 1 | Serial grant pin from the arbiter |
| ack | output | NCH | One-hot acknowledge of the granted channel |
| io_cyc | input | 1 | I/O cycle addressed to this agent, one clock |
| io_rd | input | 1 | 1 = read, 0 = write |
| io_addr | input | AW | I/O cycle offset |
| data_stb | output | 1 | Data-transfer strobe |
| verify_stb | output | 1 | Verify strobe |
| tc_flag | output | 1 | Terminal-count marker accompanying a strobe |

## Verification
The hardest situations to reach are the ones where framing and granting interact. A two-clock drop gap needs a completed frame, then a fully decoded grant, then a request drop for exactly the granted channel while the framer idles in its tail. A resend needs the grant to end while `chan_req` is unchanged. The stimulus builds these in order: it sends a grant message bit by bit on `gnt_n`, drops the served channel, and then releases `gnt_n`. A separate frame capture changes the requests in the middle of the bit stream to show that the snapshot is kept.

// File: rtl/dma_req_link_pkg.sv
package dma_req_link_pkg;
  typedef enum logic [2:0] {FR_IDLE, FR_GAP, FR_START, FR_BITS, FR_TAIL} frame_st_t;
  typedef enum logic [1:0] {GD_IDLE, GD_BITS, GD_HOLD} gnt_st_t;
  localparam logic [7:0] OFS_XFER    = 8'h00;
  localparam logic [7:0] OFS_XFER_TC = 8'h04;
  localparam logic [7:0] OFS_VFY     = 8'hC0;
  localparam logic [7:0] OFS_VFY_TC  = 8'hC4;
endpackage

// File: rtl/req_framer.sv
module req_framer
  import dma_req_link_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] chan_req,
  input  logic [CW-1:0]  serve_chan,
  input  logic           serve_live,
  input  logic           grant_end,
  output logic           req_n
);
  frame_st_t      st;
  logic [NCH-1:0] snap;
  logic [CW-1:0]  idx;
  logic           gap2;
  logic           resend_q;
  logic           req_q;
  logic [NCH-1:0] serve_mask;
  logic           others, resend_now, served_drop, upd;

  always_comb begin
    serve_mask  = {{(NCH-1){1'b0}}, 1'b1} << serve_chan;
    others      = |(snap & ~serve_mask);
    resend_now  = resend_q | (grant_end & others);
    served_drop = serve_live & (|(snap & serve_mask)) & ~(|(chan_req & serve_mask));
    upd         = (chan_req != snap) | resend_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FR_IDLE;
      snap     <= '0;
      idx      <= '0;
      gap2     <= 1'b0;
      resend_q <= 1'b0;
      req_q    <= 1'b1;
    end else begin
      if (grant_end & others) resend_q <= 1'b1;
      case (st)
        FR_IDLE: if (upd) begin
          st       <= FR_START;
          snap     <= chan_req;
          resend_q <= 1'b0;
          req_q    <= 1'b0;
        end
        FR_TAIL: if (upd) begin
          st    <= FR_GAP;
          gap2  <= served_drop;
          req_q <= 1'b1;
        end
        FR_GAP: begin
          if (gap2) begin
            gap2 <= 1'b0;
          end else begin
            st       <= FR_START;
            snap     <= chan_req;
            resend_q <= 1'b0;
            req_q    <= 1'b0;
          end
        end
        FR_START: begin
          st    <= FR_BITS;
          idx   <= '0;
          req_q <= ~snap[0];
        end
        FR_BITS: begin
          if (idx == CW'(NCH-1)) begin
            if (snap == '0) begin
              st    <= FR_IDLE;
              req_q <= 1'b1;
            end else begin
              st    <= FR_TAIL;
              req_q <= 1'b0;
            end
          end else begin
            idx   <= idx + CW'(1);
            req_q <= ~snap[idx + CW'(1)];
          end
        end
        default: begin
          st    <= FR_IDLE;
          req_q <= 1'b1;
        end
      endcase
    end
  end

  assign req_n = req_q;
endmodule

// File: rtl/gnt_deser.sv
module gnt_deser
  import dma_req_link_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           gnt_n,
  output logic [NCH-1:0] ack,
  output logic [CW-1:0]  chan,
  output logic           live,
  output logic           grant_end
);
  gnt_st_t        st;
  logic [CW-1:0]  shf;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  nxt;
  logic [NCH-1:0] ack_q;
  logic           live_q, end_q;

  always_comb nxt = CW'({gnt_n, shf} >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= GD_IDLE;
      shf    <= '0;
      cnt    <= '0;
      ack_q  <= '0;
      live_q <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      end_q <= 1'b0;
      case (st)
        GD_IDLE: if (!gnt_n) begin
          st  <= GD_BITS;
          cnt <= '0;
        end
        GD_BITS: begin
          shf <= nxt;
          if (cnt == CW'(CW-1)) begin
            st     <= GD_HOLD;
            live_q <= 1'b1;
            ack_q  <= {{(NCH-1){1'b0}}, 1'b1} << nxt;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        GD_HOLD: if (gnt_n) begin
          st     <= GD_IDLE;
          live_q <= 1'b0;
          ack_q  <= '0;
          end_q  <= 1'b1;
        end
        default: st <= GD_IDLE;
      endcase
    end
  end

  assign ack       = ack_q;
  assign chan      = shf;
  assign live      = live_q;
  assign grant_end = end_q;
endmodule

// File: rtl/io_cmd_decode.sv
module io_cmd_decode
  import dma_req_link_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_cyc,
  input  logic          io_rd,
  input  logic [AW-1:0] io_addr,
  input  logic          live,
  output logic          data_stb,
  output logic          verify_stb,
  output logic          tc_flag
);
  logic hit_x, hit_xt, hit_v, hit_vt, go_d, go_v;

  always_comb begin
    hit_x  = (io_addr == AW'(OFS_XFER));
    hit_xt = (io_addr == AW'(OFS_XFER_TC));
    hit_v  = (io_addr == AW'(OFS_VFY));
    hit_vt = (io_addr == AW'(OFS_VFY_TC));
    go_d   = io_cyc & live & (hit_x | hit_xt);
    go_v   = io_cyc & live & io_rd & (hit_v | hit_vt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_stb   <= 1'b0;
      verify_stb <= 1'b0;
      tc_flag    <= 1'b0;
    end else begin
      data_stb   <= go_d;
      verify_stb <= go_v;
      tc_flag    <= (go_d & hit_xt) | (go_v & hit_vt);
    end
  end
endmodule

// File: rtl/dma_req_link.sv
module dma_req_link #(
  parameter int NCH = 8,
  parameter int AW  = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] chan_req,
  output logic           req_n,
  input  logic           gnt_n,
  output logic [NCH-1:0] ack,
  input  logic           io_cyc,
  input  logic           io_rd,
  input  logic [AW-1:0]  io_addr,
  output logic           data_stb,
  output logic           verify_stb,
  output logic           tc_flag
);
  logic [CW-1:0] g_chan;
  logic          g_live, g_end;

  gnt_deser #(.NCH(NCH)) u_gnt (
    .clk(clk), .rst(rst), .gnt_n(gnt_n), .ack(ack),
    .chan(g_chan), .live(g_live), .grant_end(g_end)
  );

  req_framer #(.NCH(NCH)) u_frm (
    .clk(clk), .rst(rst), .chan_req(chan_req), .serve_chan(g_chan),
    .serve_live(g_live), .grant_end(g_end), .req_n(req_n)
  );

  io_cmd_decode #(.AW(AW)) u_io (
    .clk(clk), .rst(rst), .io_cyc(io_cyc), .io_rd(io_rd), .io_addr(io_addr),
    .live(g_live), .data_stb(data_stb), .verify_stb(verify_stb), .tc_flag(tc_flag)
  );
endmodule

// File: rtl/dma_req_link_chk.sv
module dma_req_link_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           req_n,
  input logic           gnt_n,
  input logic [NCH-1:0] ack,
  input logic           io_cyc,
  input logic           io_rd,
  input logic           data_stb,
  input logic           verify_stb,
  input logic           tc_flag
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (req_n && ack == '0 && !data_stb && !verify_stb && !tc_flag)); // R1
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack)); // R7
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((|ack) && !gnt_n) |=> (ack == $past(ack))); // R7
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((|ack) && gnt_n) |=> (ack == '0)); // R7
  AST_STB_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (data_stb || verify_stb) |-> $past(io_cyc)); // R8
  AST_VFY_READ: assert property (@(posedge clk) disable iff (rst)
    verify_stb |-> $past(io_rd)); // R8
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(data_stb && verify_stb)); // R9
endmodule

bind dma_req_link dma_req_link_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .req_n(req_n), .gnt_n(gnt_n), .ack(ack),
  .io_cyc(io_cyc), .io_rd(io_rd), .data_stb(data_stb),
  .verify_stb(verify_stb), .tc_flag(tc_flag)
);

// File: tb/dma_req_link_test.sv
`timescale 1ns/1ps
module dma_req_link_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] chan_req = '0;
  logic       req_n;
  logic       gnt_n = 1'b1;
  logic [7:0] ack;
  logic       io_cyc = 1'b0;
  logic       io_rd = 1'b0;
  logic [7:0] io_addr = '0;
  logic       data_stb, verify_stb, tc_flag;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_req_link uut (
    .clk(clk), .rst(rst), .chan_req(chan_req), .req_n(req_n), .gnt_n(gnt_n),
    .ack(ack), .io_cyc(io_cyc), .io_rd(io_rd), .io_addr(io_addr),
    .data_stb(data_stb), .verify_stb(verify_stb), .tc_flag(tc_flag)
  );

  // {rd, addr[7:0], exp data, exp verify, exp tc}
  localparam int NV = 9;
  localparam logic [11:0] IO_VEC [NV] = '{
    {1'b1, 8'h00, 3'b100}, {1'b0, 8'h00, 3'b100}, {1'b0, 8'h04, 3'b101},
    {1'b1, 8'hC0, 3'b010}, {1'b1, 8'hC4, 3'b011}, {1'b0, 8'hC0, 3'b000},
    {1'b1, 8'h08, 3'b000}, {1'b1, 8'hC8, 3'b000}, {1'b1, 8'h80, 3'b000}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic get_frame(input logic [7:0] exp_bits, input int exp_gap, input string req,
                           input bit mid_en, input logic [7:0] mid_val);
    int gap = 0;
    logic [7:0] got = '0;
    @(negedge clk);
    while (req_n && gap < 40) begin
      gap++;
      @(negedge clk);
    end
    if (exp_gap >= 0) chk(gap == exp_gap, {req, " gap"}, gap, exp_gap);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      got[i] = ~req_n;
      if (mid_en && i == 3) chan_req = mid_val;
    end
    chk(got == exp_bits, {req, " bits"}, got, exp_bits);
  endtask

  task automatic send_grant(input logic [2:0] ch);
    @(negedge clk) gnt_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) gnt_n = ch[i];
      if (i == 2) chk(ack == 8'h00, "R7 no ack during message", ack, 0);
    end
    @(negedge clk) gnt_n = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_n == 1'b1 && ack == 8'h00, "R1 reset req/ack", {req_n, ack}, 9'h100);
    chk(!data_stb && !verify_stb && !tc_flag, "R1 reset strobes",
        {data_stb, verify_stb, tc_flag}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_n == 1'b1, "R1 idle after reset", req_n, 1);

    // R2: frame from idle
    chan_req = 8'h24;
    get_frame(8'h24, 0, "R2 first frame", 0, 8'h00);
    @(negedge clk);
    chk(req_n == 1'b0, "R2 tail low", req_n, 0);
    @(negedge clk);
    chk(req_n == 1'b0, "R2 tail held", req_n, 0);

    // R3: change in tail, then change in the middle of a frame
    chan_req = 8'h25;
    get_frame(8'h25, 1, "R3 tail change", 0, 8'h00);
    @(negedge clk);
    chan_req = 8'h27;
    get_frame(8'h27, 1, "R3 frame snapshot", 1, 8'h07);
    @(negedge clk);
    chk(req_n == 1'b0, "R3 tail before deferred update", req_n, 0);
    get_frame(8'h07, 1, "R3 deferred update", 0, 8'h00);
    @(negedge clk);

    // R7: grant channel 2
    send_grant(3'd2);
    chk(ack == 8'h04, "R7 ack channel 2", ack, 8'h04);
    repeat (3) @(negedge clk);
    chk(ack == 8'h04, "R7 ack held", ack, 8'h04);
    chk(req_n == 1'b0, "R7 grant leaves framer in tail", req_n, 0);

    // R8/R9: I/O offset table during grant
    for (int v = 0; v < NV; v++) begin
      io_cyc = 1'b1;
      io_rd = IO_VEC[v][11];
      io_addr = IO_VEC[v][10:3];
      @(negedge clk);
      chk({data_stb, verify_stb, tc_flag} == IO_VEC[v][2:0],
          (IO_VEC[v][2:0] == 3'b000) ? "R9 io no strobe" : "R8 io decode",
          {data_stb, verify_stb, tc_flag}, IO_VEC[v][2:0]);
    end
    io_cyc = 1'b0;
    @(negedge clk);
    chk(!data_stb && !verify_stb, "R8 strobe one clock", {data_stb, verify_stb}, 0);

    // R4: served channel drops
    chan_req = 8'h03;
    get_frame(8'h03, 2, "R4 served drop", 0, 8'h00);
    @(negedge clk);
    chk(req_n == 1'b0, "R4 tail after drop frame", req_n, 0);

    // R6: grant ends with others outstanding
    gnt_n = 1'b1;
    @(negedge clk);
    chk(ack == 8'h00, "R7 ack cleared", ack, 0);
    get_frame(8'h03, 1, "R6 resend after grant", 0, 8'h00);
    @(negedge clk);
    chk(req_n == 1'b0, "R6 tail after resend", req_n, 0);
    repeat (3) @(negedge clk);
    chk(req_n == 1'b0, "R6 no further resend", req_n, 0);

    // R5: empty set
    chan_req = 8'h00;
    get_frame(8'h00, 1, "R5 empty frame", 0, 8'h00);
    @(negedge clk);
    chk(req_n == 1'b1, "R5 idle after empty", req_n, 1);
    repeat (4) @(negedge clk);
    chk(req_n == 1'b1, "R5 stays idle", req_n, 1);

    // R9: no grant, no strobe
    io_cyc = 1'b1; io_rd = 1'b1; io_addr = 8'h00;
    @(negedge clk);
    io_cyc = 1'b0;
    chk(!data_stb, "R9 no strobe without grant", data_stb, 0);

    // R7: grant channel 7 from idle
    send_grant(3'd7);
    chk(ack == 8'h80, "R7 ack channel 7", ack, 8'h80);
    gnt_n = 1'b1;
    @(negedge clk);
    chk(ack == 8'h00, "R7 ack channel 7 cleared", ack, 0);
    @(negedge clk);
    chk(req_n == 1'b1, "R6 no resend with empty set", req_n, 1);

    // R1: reset in mid-frame
    chan_req = 8'hFF;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    chan_req = 8'h00;
    @(negedge clk);
    chk(req_n == 1'b1, "R1 reset mid-frame", req_n, 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_n == 1'b1, "R1 idle after second reset", req_n, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule